// File: doc/BRIEF.md
# Two-Domain Power-State Sequencer

This controller brings a two-processor subsystem out of power-up and then moves it between full-power and low-power operation. It works through a fixed sequence. First it enables the clock of the management side while that side is held in reset. It then releases that reset and runs a chain of configuration steps: clock/DLL to full rate, pad routing, and the user clock to full speed. Once those steps are done, it lets the user side out of reset.

The external clock-generator supply stays enabled until the user side reports healthy operation and the sequencer has acknowledged that report. After that point, the user side asks for power changes by writing a message code into a mailbox register. The write raises an interrupt-pending flag. The sequencer consumes the message and reconfigures the clock/DLL toward its lowest-power or full-power setting. It then answers with a one-cycle reply carrying the code of the state it has reached.

Each configuration step is a request/acknowledge exchange on a shared step port. A programmable cycle limit guards every step. A step that exceeds the limit parks the sequencer in a sticky error state with a fault flag raised.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `mgmt_rst`=1, `mgmt_clk_en`=0, `user_rst`=1, `cgen_pwr_en`=1, `step_req`=0, `dll_full`=0, `mbox_irq`=0, `reply_valid`=0 and `fault`=0.
- R2: `mgmt_clk_en` rises on the first clock edge after reset is released. `mgmt_rst` falls RST_HOLD edges later, on the same edge that raises `step_req` for the first step.
- R3: The bring-up steps are requested in the order `step_sel`=0 (clock/DLL full), 1 (pad routing), 2 (user clock full). `step_req` stays high across them, and `step_sel` advances on the edge that samples `step_ack`=1. `dll_full` rises with the acknowledge of step 0.
- R4: `user_rst` falls on the edge that samples the acknowledge of step 2. With an acknowledge that comes d cycles after each request is seen, this is edge RST_HOLD+6+3d after reset release.
- R5: `run_ok_ack` rises one edge after `user_run_ok` is sampled high in the wait state. `cgen_pwr_en` falls one edge after that. It never falls before.
- R6: A register write to address 0 with data 8'h01 (go low) or 8'h02 (go full) stores the code and raises `mbox_irq`. The flag clears on the edge where the sequencer consumes the message. Any other data value is dropped: no flag, no reply, no step, no state change.
- R7: A go-low message in the running state requests step 3 (clock/DLL low). Its acknowledge clears `dll_full`, enters the low-power state and pulses `reply_valid` with `reply_code`=2'b01.
- R8: A go-full message in the low-power state requests step 0. Its acknowledge sets `dll_full`, re-enters the running state and pulses `reply_valid` with `reply_code`=2'b10.
- R9: A go-low message while in low power, or a go-full message while running, produces a reply with the same code one edge after it is consumed. No step is requested, and `dll_full` is unchanged.
- R10: The step limit (address 1, reset value TMO_DEF) is counted from the cycle `step_req` is first seen for a step. If no acknowledge has arrived by cycle index equal to the limit, `fault` rises and `step_req` falls on the edge after that cycle. Both then hold until reset, whatever `step_ack` does.
- R11: Reads return, one cycle after `reg_addr` is presented: at address 0 the stored code, at address 1 the limit, and at address 2 the status {fault, cgen_pwr_en, dll_full, mbox_irq, 0, state[2:0]}. The state codes are reset 0, management clock 1, configure 2, user full 3, run wait 4, running 5, low power 6, error 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (write and read) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for the address of the previous cycle |
| mbox_irq | output | 1 | Mailbox message pending |
| mgmt_clk_en | output | 1 | Management core clock enable |
| mgmt_rst | output | 1 | Management core reset |
| user_rst | output | 1 | User logic reset |
| step_req | output | 1 | Configuration step request |
| step_sel | output | 2 | Step being requested (0 DLL full, 1 pads, 2 user clock, 3 DLL low) |
| step_ack | input | 1 | One-cycle step acknowledge |
| dll_full | output | 1 | Clock/DLL configured at full rate |
| user_run_ok | input | 1 | User side reports healthy operation |
| run_ok_ack | output | 1 | Acknowledge of the healthy report |
| cgen_pwr_en | output | 1 | External clock-generator power enable |
| reply_valid | output | 1 | One-cycle reply pulse to the user side |
| reply_code | output | 2 | Reply code (01 low reached, 10 full reached) |
| fault | output | 1 | Step timeout fault, sticky |

## Verification
A corrupted state register or step index appears on `step_sel`, `step_req` or the reset outputs within one edge. The bench compares the exact edge at which each reset, request and enable changes against counts derived from the acknowledge delay. A stuck or stale mailbox flag appears as a missing or extra reply pulse within two cycles of a write. A mis-counted step timer shifts the rise of `fault` by at least one cycle, and the bench samples it on both sides of the expected edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET         = 3'd0,
    ST_MGMT_CLK      = 3'd1,
    ST_CONFIG        = 3'd2,
    ST_USER_FULL     = 3'd3,
    ST_USER_RUN_WAIT = 3'd4,
    ST_RUNNING       = 3'd5,
    ST_LOW_POWER     = 3'd6,
    ST_ERROR         = 3'd7
  } pseq_state_e;

  typedef enum logic [1:0] {
    STEP_DLL_FULL = 2'd0,
    STEP_PAD      = 2'd1,
    STEP_UCLK     = 2'd2,
    STEP_DLL_LOW  = 2'd3
  } pseq_step_e;

  localparam logic [1:0] MSG_LOW  = 2'b01;
  localparam logic [1:0] MSG_FULL = 2'b10;

  localparam logic [1:0] ADDR_MBOX   = 2'd0;
  localparam logic [1:0] ADDR_LIMIT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TMO_W   = 8,
  parameter int TMO_DEF = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             consume,
  input  logic [DW-1:0]    status,
  output logic [1:0]       code,
  output logic             pend,
  output logic [TMO_W-1:0] limit,
  output logic [DW-1:0]    rdata
);

  logic code_ok;

  assign code_ok = (wdata == DW'(MSG_LOW)) || (wdata == DW'(MSG_FULL));

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= 2'b00;
      pend  <= 1'b0;
      limit <= TMO_W'(TMO_DEF);
    end else begin
      if (wr && addr == ADDR_MBOX && code_ok) begin
        code <= wdata[1:0];
        pend <= 1'b1;
      end else if (consume) begin
        pend <= 1'b0;
      end
      if (wr && addr == ADDR_LIMIT) begin
        limit <= wdata[TMO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        ADDR_MBOX:   rdata <= DW'(code);
        ADDR_LIMIT:  rdata <= DW'(limit);
        ADDR_STATUS: rdata <= status;
        default:     rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pwr_seq_step_timer.sv
module pwr_seq_step_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             ack,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);

  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !req || ack) begin
      cnt <= '0;
    end else if (cnt != {TMO_W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = req && !ack && (cnt >= limit);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mb_pend,
  input  logic [1:0]  mb_code,
  input  logic        expire,
  input  logic        step_ack,
  input  logic        user_run_ok,
  output logic        consume,
  output pseq_state_e state,
  output logic        mgmt_clk_en,
  output logic        mgmt_rst,
  output logic        user_rst,
  output logic        step_req,
  output logic [1:0]  step_sel,
  output logic        dll_full,
  output logic        run_ok_ack,
  output logic        cgen_pwr_en,
  output logic        reply_valid,
  output logic [1:0]  reply_code,
  output logic        fault
);

  localparam int HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);

  logic [HW-1:0] hold_q;
  pseq_step_e    sel_q;

  assign step_sel = sel_q;
  assign consume  = mb_pend && !step_req &&
                    (state == ST_RUNNING || state == ST_LOW_POWER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RESET;
      hold_q      <= '0;
      sel_q       <= STEP_DLL_FULL;
      mgmt_clk_en <= 1'b0;
      mgmt_rst    <= 1'b1;
      user_rst    <= 1'b1;
      step_req    <= 1'b0;
      dll_full    <= 1'b0;
      run_ok_ack  <= 1'b0;
      cgen_pwr_en <= 1'b1;
      reply_valid <= 1'b0;
      reply_code  <= 2'b00;
      fault       <= 1'b0;
    end else begin
      reply_valid <= 1'b0;
      unique case (state)
        ST_RESET: begin
          mgmt_clk_en <= 1'b1;
          state       <= ST_MGMT_CLK;
        end
        ST_MGMT_CLK: begin
          if (hold_q == HOLD_LAST) begin
            mgmt_rst <= 1'b0;
            step_req <= 1'b1;
            sel_q    <= STEP_DLL_FULL;
            state    <= ST_CONFIG;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_CONFIG: begin
          if (expire) begin
            step_req <= 1'b0;
            fault    <= 1'b1;
            state    <= ST_ERROR;
          end else if (step_ack) begin
            if (sel_q == STEP_DLL_FULL) begin
              dll_full <= 1'b1;
              sel_q    <= STEP_PAD;
            end else begin
              sel_q <= STEP_UCLK;
              state <= ST_USER_FULL;
            end
          end
        end
        ST_USER_FULL: begin
          if (expire) begin
            step_req <= 1'b0;
            fault    <= 1'b1;
            state    <= ST_ERROR;
          end else if (step_ack) begin
            step_req <= 1'b0;
            user_rst <= 1'b0;
            state    <= ST_USER_RUN_WAIT;
          end
        end
        ST_USER_RUN_WAIT: begin
          if (run_ok_ack) begin
            cgen_pwr_en <= 1'b0;
            state       <= ST_RUNNING;
          end else if (user_run_ok) begin
            run_ok_ack <= 1'b1;
          end
        end
        ST_RUNNING: begin
          if (step_req) begin
            if (expire) begin
              step_req <= 1'b0;
              fault    <= 1'b1;
              state    <= ST_ERROR;
            end else if (step_ack) begin
              step_req    <= 1'b0;
              dll_full    <= 1'b0;
              state       <= ST_LOW_POWER;
              reply_valid <= 1'b1;
              reply_code  <= MSG_LOW;
            end
          end else if (mb_pend) begin
            if (mb_code == MSG_LOW) begin
              step_req <= 1'b1;
              sel_q    <= STEP_DLL_LOW;
            end else begin
              reply_valid <= 1'b1;
              reply_code  <= MSG_FULL;
            end
          end
        end
        ST_LOW_POWER: begin
          if (step_req) begin
            if (expire) begin
              step_req <= 1'b0;
              fault    <= 1'b1;
              state    <= ST_ERROR;
            end else if (step_ack) begin
              step_req    <= 1'b0;
              dll_full    <= 1'b1;
              state       <= ST_RUNNING;
              reply_valid <= 1'b1;
              reply_code  <= MSG_FULL;
            end
          end else if (mb_pend) begin
            if (mb_code == MSG_FULL) begin
              step_req <= 1'b1;
              sel_q    <= STEP_DLL_FULL;
            end else begin
              reply_valid <= 1'b1;
              reply_code  <= MSG_LOW;
            end
          end
        end
        ST_ERROR: begin
          step_req <= 1'b0;
          fault    <= 1'b1;
        end
        default: state <= ST_ERROR;
      endcase
    end
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TMO_W    = 8,
  parameter int TMO_DEF  = 16,
  parameter int RST_HOLD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mbox_irq,
  output logic          mgmt_clk_en,
  output logic          mgmt_rst,
  output logic          user_rst,
  output logic          step_req,
  output logic [1:0]    step_sel,
  input  logic          step_ack,
  output logic          dll_full,
  input  logic          user_run_ok,
  output logic          run_ok_ack,
  output logic          cgen_pwr_en,
  output logic          reply_valid,
  output logic [1:0]    reply_code,
  output logic          fault
);

  logic             consume;
  logic [1:0]       mb_code;
  logic [TMO_W-1:0] limit;
  logic             expire;
  pseq_state_e      state;
  logic [DW-1:0]    status;

  assign status = DW'({fault, cgen_pwr_en, dll_full, mbox_irq, 1'b0, state});

  pwr_seq_regs #(.DW(DW), .TMO_W(TMO_W), .TMO_DEF(TMO_DEF)) i_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .consume(consume), .status(status), .code(mb_code), .pend(mbox_irq),
    .limit(limit), .rdata(reg_rdata)
  );

  pwr_seq_step_timer #(.TMO_W(TMO_W)) i_timer (
    .clk(clk), .rst(rst), .req(step_req), .ack(step_ack),
    .limit(limit), .expire(expire)
  );

  pwr_seq_fsm #(.RST_HOLD(RST_HOLD)) i_fsm (
    .clk(clk), .rst(rst), .mb_pend(mbox_irq), .mb_code(mb_code),
    .expire(expire), .step_ack(step_ack), .user_run_ok(user_run_ok),
    .consume(consume), .state(state), .mgmt_clk_en(mgmt_clk_en),
    .mgmt_rst(mgmt_rst), .user_rst(user_rst), .step_req(step_req),
    .step_sel(step_sel), .dll_full(dll_full), .run_ok_ack(run_ok_ack),
    .cgen_pwr_en(cgen_pwr_en), .reply_valid(reply_valid),
    .reply_code(reply_code), .fault(fault)
  );

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mgmt_clk_en,
  input logic       mgmt_rst,
  input logic       user_rst,
  input logic       step_req,
  input logic [1:0] step_sel,
  input logic       step_ack,
  input logic       dll_full,
  input logic       run_ok_ack,
  input logic       cgen_pwr_en,
  input logic       reply_valid,
  input logic [1:0] reply_code,
  input logic       fault
);

  // R2
  mgmt_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mgmt_rst) |-> mgmt_clk_en && step_req);

  // R4
  user_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(user_rst) |-> $past(step_req) && $past(step_ack) && $past(step_sel) == 2'd2);

  // R5
  pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cgen_pwr_en) |-> $past(run_ok_ack) && !user_rst);

  // R7
  low_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (reply_valid && reply_code == 2'b01) |-> !dll_full);

  // R8
  full_reply_chk: assert property (@(posedge clk) disable iff (rst)
    (reply_valid && reply_code == 2'b10) |-> dll_full);

  // R9
  reply_code_chk: assert property (@(posedge clk) disable iff (rst)
    reply_valid |-> (reply_code == 2'b01 || reply_code == 2'b10));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault && !step_req);

endmodule

bind pwr_seq_top pwr_seq_chk i_chk (
  .clk(clk), .rst(rst), .mgmt_clk_en(mgmt_clk_en), .mgmt_rst(mgmt_rst),
  .user_rst(user_rst), .step_req(step_req), .step_sel(step_sel),
  .step_ack(step_ack), .dll_full(dll_full), .run_ok_ack(run_ok_ack),
  .cgen_pwr_en(cgen_pwr_en), .reply_valid(reply_valid),
  .reply_code(reply_code), .fault(fault)
);

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;

  localparam int HOLD = 4;
  localparam int DEFL = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       mbox_irq, mgmt_clk_en, mgmt_rst, user_rst, step_req;
  logic [1:0] step_sel;
  logic       step_ack = 1'b0;
  logic       dll_full;
  logic       user_run_ok = 1'b0;
  logic       run_ok_ack, cgen_pwr_en, reply_valid, fault;
  logic [1:0] reply_code;

  int n_cmp = 0;
  int n_bad = 0;
  int ack_delay = 0;
  bit ack_en = 1'b1;
  int wcnt = 0;
  int ack_n = 0;
  int ack_log [0:7];
  int rep_cnt = 0;
  int rep_last = 0;

  always #10 clk = ~clk;

  pwr_seq_top #(.DW(8), .TMO_W(8), .TMO_DEF(DEFL), .RST_HOLD(HOLD)) i_pwr_seq_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mbox_irq(mbox_irq),
    .mgmt_clk_en(mgmt_clk_en), .mgmt_rst(mgmt_rst), .user_rst(user_rst),
    .step_req(step_req), .step_sel(step_sel), .step_ack(step_ack),
    .dll_full(dll_full), .user_run_ok(user_run_ok), .run_ok_ack(run_ok_ack),
    .cgen_pwr_en(cgen_pwr_en), .reply_valid(reply_valid),
    .reply_code(reply_code), .fault(fault)
  );

  // Peer that acknowledges steps after ack_delay cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (step_ack) begin
        step_ack = 1'b0;
        wcnt = 0;
      end else if (step_req && ack_en) begin
        if (wcnt == ack_delay) begin
          step_ack = 1'b1;
          if (ack_n < 8) ack_log[ack_n] = int'(step_sel);
          ack_n++;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  // Reply monitor, samples the previous cycle's values at the edge.
  initial begin
    forever begin
      @(posedge clk);
      if (reply_valid) begin
        rep_cnt++;
        rep_last = int'(reply_code);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_addr = 2'd2;
  endtask

  task automatic start_reset();
    @(negedge clk);
    rst = 1'b1;
    user_run_ok = 1'b0;
    ack_n = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_reply(input int rc);
    for (int i = 0; i < 80 && rep_cnt == rc; i++) @(negedge clk);
  endtask

  task automatic bring_up(input int d);
    int n;
    int v;
    bit seen_rel;
    ack_delay = d;
    ack_en = 1'b1;
    start_reset();
    // R1 reset values while rst is high
    chk("R1 mgmt_rst", mgmt_rst, 1);
    chk("R1 clk_en", mgmt_clk_en, 0);
    chk("R1 user_rst", user_rst, 1);
    chk("R1 pwr_en", cgen_pwr_en, 1);
    chk("R1 outs", {step_req, dll_full, mbox_irq, reply_valid, fault}, 0);
    rst = 1'b0;
    n = 0;
    seen_rel = 1'b0;
    for (int i = 0; i < 200 && user_rst; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk("R2 clk_en first edge", mgmt_clk_en, 1);
        chk("R2 mgmt_rst held", mgmt_rst, 1);
      end
      if (!mgmt_rst && !seen_rel) begin
        seen_rel = 1'b1;
        chk("R2 mgmt_rst release edge", n, HOLD + 1);
        chk("R2 first request", {step_req, step_sel}, 3'b100);
      end
    end
    chk("R4 user_rst release edge", n, HOLD + 6 + 3 * d);
    chk("R3 ack count", ack_n, 3);
    chk("R3 step order 0", ack_log[0], 0);
    chk("R3 step order 1", ack_log[1], 1);
    chk("R3 step order 2", ack_log[2], 2);
    chk("R3 dll_full after config", dll_full, 1);
    repeat (3) @(negedge clk);
    chk("R5 pwr held before report", cgen_pwr_en, 1);
    user_run_ok = 1'b1;
    @(negedge clk);
    chk("R5 report ack", run_ok_ack, 1);
    chk("R5 pwr still on", cgen_pwr_en, 1);
    @(negedge clk);
    chk("R5 pwr off", cgen_pwr_en, 0);
    read_reg(2'd2, v);
    chk("R11 status running", v, 8'h25);
  endtask

  // Write a code; returns at the negedge after the write edge.
  task automatic mbox(input logic [7:0] c);
    wr_reg(2'd0, c);
  endtask

  task automatic go_low();
    int rc;
    int v;
    rc = rep_cnt;
    mbox(8'h01);
    chk("R6 irq set", mbox_irq, 1);
    @(negedge clk);
    chk("R6 irq cleared on consume", mbox_irq, 0);
    chk("R7 low step", {step_req, step_sel}, 3'b111);
    wait_reply(rc);
    @(negedge clk);
    chk("R7 reply count", rep_cnt, rc + 1);
    chk("R7 reply code", rep_last, 1);
    chk("R7 dll low", dll_full, 0);
    read_reg(2'd2, v);
    chk("R11 status low", v, 8'h06);
  endtask

  task automatic go_full();
    int rc;
    int v;
    rc = rep_cnt;
    mbox(8'h02);
    chk("R6 irq set full", mbox_irq, 1);
    @(negedge clk);
    chk("R8 full step", {step_req, step_sel}, 3'b100);
    wait_reply(rc);
    @(negedge clk);
    chk("R8 reply count", rep_cnt, rc + 1);
    chk("R8 reply code", rep_last, 2);
    chk("R8 dll full", dll_full, 1);
    read_reg(2'd2, v);
    chk("R11 status running again", v, 8'h25);
  endtask

  task automatic dup(input logic [7:0] c, input int dll_exp);
    int rc;
    rc = rep_cnt;
    mbox(c);
    @(negedge clk);
    chk("R9 no step on repeat", step_req, 0);
    @(negedge clk);
    chk("R9 immediate reply", rep_cnt, rc + 1);
    chk("R9 reply code", rep_last, int'(c));
    chk("R9 dll unchanged", dll_full, dll_exp);
  endtask

  task automatic junk(input logic [7:0] c, input int status_exp);
    int rc;
    int v;
    rc = rep_cnt;
    mbox(c);
    chk("R6 junk no irq", mbox_irq, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R6 junk no step", step_req, 0);
    end
    chk("R6 junk no reply", rep_cnt, rc);
    read_reg(2'd2, v);
    chk("R6 junk state kept", v, status_exp);
  endtask

  task automatic timeout_check(input int lim, input int status_exp);
    int r;
    int v;
    r = 0;
    for (int i = 0; i < 100 && !step_req; i++) @(negedge clk);
    repeat (lim) @(negedge clk);
    chk("R10 no fault before limit", fault, 0);
    chk("R10 request held", step_req, 1);
    @(negedge clk);
    chk("R10 fault at limit", fault, 1);
    chk("R10 request dropped", step_req, 0);
    ack_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 fault sticky", fault, 1);
    chk("R10 no request in error", step_req, 0);
    read_reg(2'd2, v);
    chk("R11 status error", v, status_exp);
  endtask

  initial begin
    int v;
    for (int d = 0; d < 3; d++) begin
      bring_up(d);
      read_reg(2'd1, v);
      chk("R11 limit default", v, DEFL);
      junk(8'h00, 8'h25);
      junk(8'h03, 8'h25);
      dup(8'h02, 1);
      go_low();
      junk(8'h00, 8'h06);
      junk(8'hFF, 8'h06);
      dup(8'h01, 0);
      read_reg(2'd0, v);
      chk("R11 code readback", v, 1);
      go_full();
      read_reg(2'd0, v);
      chk("R11 code readback full", v, 2);
    end

    // Timeouts during configuration, sweep of limits.
    for (int lim = 2; lim < 5; lim++) begin
      ack_en = 1'b0;
      start_reset();
      rst = 1'b0;
      reg_wr = 1'b1;
      reg_addr = 2'd1;
      reg_wdata = 8'(lim);
      @(negedge clk);
      reg_wr = 1'b0;
      reg_addr = 2'd2;
      timeout_check(lim, 8'hC7);
    end

    // Timeout on a return to full power.
    bring_up(1);
    go_low();
    wr_reg(2'd1, 8'd3);
    read_reg(2'd1, v);
    chk("R11 limit written", v, 3);
    ack_en = 1'b0;
    mbox(8'h02);
    timeout_check(3, 8'h87);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule